// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines into a status register and drives one interrupt line to a processor. A processor reaches it over a simple 32-bit register bus with a word address, a write strobe, write data, a read strobe and read data. Each line is captured either on its rising edge or as a level. The choice is fixed per line by a parameter mask.

Captured requests are gated by a per-line enable and by a two-bit master control. Software reads a vector register that names the lowest-numbered pending line, or all ones when nothing is pending. It services that line and clears it by writing a one to its bit in the acknowledge register. Enables can be loaded as a whole, or changed bit by bit through separate set and clear aliases, so no read-modify-write is needed.

Top module: `irqc_top`

## Requirements
- R1: While the reset is applied and after it is released, status, enable and master control all read zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: A line whose bit in `KIND_MASK` is one sets its status bit on a rising edge. The status bit stays set after the line falls. A line held high through an acknowledge is not captured again until it falls and rises again.
- R3: A line whose bit in `KIND_MASK` is zero sets its status bit in every cycle in which it is high. Acknowledging it while it is still high leaves the bit set. Once the line is low, an acknowledge clears the bit.
- R4: A write to word 3 (acknowledge) clears each status bit whose write-data bit is one and leaves the others unchanged. Writing 0xFFFFFFFF clears all of them.
- R5: A write to word 2 loads the enable register, so writing zero disables every line. A write to word 4 sets the enable bits given by the mask. A write to word 5 clears them. Enable bits that the mask does not name keep their value.
- R6: Word 0 reads the raw status register. Word 1 reads the pending value, which is status AND enable.
- R7: Word 6 (vector) reads the index of the lowest-numbered pending bit, which has the highest priority. It reads 0xFFFFFFFF when no bit is pending.
- R8: Word 7 holds the master control. Bit 0 is the master enable and bit 1 is the hardware-output enable. A read returns exactly the two bits last written, and the upper bits read zero.
- R9: `irq_out` is a register. It is high in the cycle after a cycle in which both master bits are one and at least one bit is pending, and it is low otherwise.
- R10: Bits at or above `N_INPUTS` read zero and ignore writes. Words 3, 4 and 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Word address (byte offset divided by 4) |
| bus_wen | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 32 | Read data, zero when `bus_ren` is low |
| irq_in | input | N_INPUTS | Interrupt request lines |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
A wrong status or enable bit appears in the same cycle on the pending and vector reads. One cycle later it appears on `irq_out`, either as an interrupt that should not be there or as one that is missing. A capture fault for a single line, such as a level line treated as an edge line, shows up only when that line is held through an acknowledge, so every line is exercised on its own in both capture modes. A priority fault shows up only for particular combinations of pending bits, so every enable pattern of the small configuration is applied over a full status register, and the vector and the output are compared against values computed in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    W_STATUS  = 3'd0,
    W_PENDING = 3'd1,
    W_ENABLE  = 3'd2,
    W_ACK     = 3'd3,
    W_EN_SET  = 3'd4,
    W_EN_CLR  = 3'd5,
    W_VECTOR  = 3'd6,
    W_MASTER  = 3'd7
  } reg_word_e;

  localparam logic [BUS_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned N_INPUTS  = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_00F0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_INPUTS-1:0] req_in,
  input  logic [N_INPUTS-1:0] ack_mask,
  output logic [N_INPUTS-1:0] status_o
);
  logic [N_INPUTS-1:0] hit;
  logic [N_INPUTS-1:0] status_d, status_q;

  for (genvar i = 0; i < N_INPUTS; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_in[i];
      end
      assign hit[i] = req_in[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = req_in[i];
    end
  end

  // a new capture wins over an acknowledge in the same cycle
  always_comb status_d = (status_q & ~ack_mask) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irqc_enables.sv
module irqc_enables #(
  parameter int unsigned N_INPUTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_we,
  input  logic [N_INPUTS-1:0] load_val,
  input  logic [N_INPUTS-1:0] set_mask,
  input  logic [N_INPUTS-1:0] clr_mask,
  input  logic                master_we,
  input  logic [1:0]          master_val,
  output logic [N_INPUTS-1:0] enable_o,
  output logic [1:0]          master_o
);
  logic [N_INPUTS-1:0] en_d, en_q;
  logic                en_ce;
  logic [1:0]          mst_q;

  always_comb begin
    en_ce = load_we | (|set_mask) | (|clr_mask);
    if (load_we) en_d = load_val;
    else         en_d = (en_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mst_q <= 2'b00;
    else if (master_we) mst_q <= master_val;
  end

  assign enable_o = en_q;
  assign master_o = mst_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N_INPUTS = 8
) (
  input  logic [N_INPUTS-1:0] pend,
  output logic [31:0]         vector_o,
  output logic                any_o
);
  always_comb begin
    vector_o = irqc_pkg::VEC_NONE;
    for (int i = N_INPUTS - 1; i >= 0; i--) begin
      if (pend[i]) vector_o = i;
    end
    any_o = |pend;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned N_INPUTS  = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_00F0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_addr,
  input  logic                bus_wen,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_ren,
  output logic [31:0]         bus_rdata,
  input  logic [N_INPUTS-1:0] irq_in,
  output logic                irq_out
);
  import irqc_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_INPUTS-1:0] wr_bits;
  logic [N_INPUTS-1:0] ack_mask, set_mask, clr_mask;
  logic                load_we, master_we;
  reg_word_e           word;

  assign word    = reg_word_e'(bus_addr);
  assign wr_bits = bus_wdata[N_INPUTS-1:0];

  always_comb begin
    ack_mask  = '0;
    set_mask  = '0;
    clr_mask  = '0;
    load_we   = 1'b0;
    master_we = 1'b0;
    if (bus_wen) begin
      unique case (word)
        W_ACK:    ack_mask  = wr_bits;
        W_EN_SET: set_mask  = wr_bits;
        W_EN_CLR: clr_mask  = wr_bits;
        W_ENABLE: load_we   = 1'b1;
        W_MASTER: master_we = 1'b1;
        default:  ;
      endcase
    end
  end

  logic [N_INPUTS-1:0] status, enable, pending;
  logic [1:0]          master;
  logic [31:0]         vector;
  logic                any_pend;

  irqc_capture #(.N_INPUTS(N_INPUTS), .KIND_MASK(KIND_MASK)) i_capture (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req_in   (irq_in),
    .ack_mask (ack_mask),
    .status_o (status)
  );

  irqc_enables #(.N_INPUTS(N_INPUTS)) i_enables (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_we    (load_we),
    .load_val   (wr_bits),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .master_we  (master_we),
    .master_val (bus_wdata[1:0]),
    .enable_o   (enable),
    .master_o   (master)
  );

  assign pending = status & enable;

  irqc_prio #(.N_INPUTS(N_INPUTS)) i_prio (
    .pend     (pending),
    .vector_o (vector),
    .any_o    (any_pend)
  );

  logic irq_d, irq_q;
  always_comb irq_d = (&master) & any_pend;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_ren) begin
      unique case (word)
        W_STATUS:  bus_rdata[N_INPUTS-1:0] = status;
        W_PENDING: bus_rdata[N_INPUTS-1:0] = pending;
        W_ENABLE:  bus_rdata[N_INPUTS-1:0] = enable;
        W_VECTOR:  bus_rdata = vector;
        W_MASTER:  bus_rdata[1:0] = master;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

module irqc_checker #(
  parameter int unsigned N_INPUTS  = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_00F0
) (
  input logic                clk,
  input logic                rst_int_n,
  input logic [N_INPUTS-1:0] irq_in,
  input logic [N_INPUTS-1:0] status,
  input logic [N_INPUTS-1:0] enable,
  input logic [N_INPUTS-1:0] ack_mask,
  input logic [N_INPUTS-1:0] set_mask,
  input logic [N_INPUTS-1:0] clr_mask,
  input logic [1:0]          master,
  input logic [31:0]         vector,
  input logic                irq_out
);
  logic [N_INPUTS-1:0] lvl_sel, pend_c;
  assign lvl_sel = ~KIND_MASK[N_INPUTS-1:0];
  assign pend_c  = status & enable;

  // R3: a high level line is in status on the next clock, acknowledged or not
  a_r3_level_capture: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ((status & $past(irq_in & lvl_sel)) == $past(irq_in & lvl_sel)));

  // R4, R2: a status bit only falls where an acknowledge named it
  a_r4_clear_only_on_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (($past(status) & ~status & ~$past(ack_mask)) == '0));

  // R5: set alias sets the named bits
  a_r5_set_alias: assert property (@(posedge clk) disable iff (!rst_int_n)
    (set_mask != '0) |=> ((enable & $past(set_mask)) == $past(set_mask)));

  // R5: clear alias clears the named bits
  a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_mask != '0) |=> ((enable & $past(clr_mask)) == '0));

  // R7: no pending bit means the all-ones vector
  a_r7_vector_none: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pend_c == '0) |-> (vector == 32'hFFFF_FFFF));

  // R7: a named vector is pending and nothing below it is
  a_r7_vector_lowest: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pend_c != '0) |-> ((vector < N_INPUTS) && pend_c[vector[4:0]]
      && ((pend_c & ((N_INPUTS'(1) << vector[4:0]) - N_INPUTS'(1))) == '0)));

  // R9: output follows the gate one cycle later
  a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((master == 2'b11) && (pend_c != '0)) |=> irq_out);

  a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((master != 2'b11) || (pend_c == '0)) |=> !irq_out);
endmodule

bind irqc_top irqc_checker #(.N_INPUTS(N_INPUTS), .KIND_MASK(KIND_MASK)) i_checker (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .irq_in    (irq_in),
  .status    (status),
  .enable    (enable),
  .ack_mask  (ack_mask),
  .set_mask  (set_mask),
  .clr_mask  (clr_mask),
  .master    (master),
  .vector    (vector),
  .irq_out   (irq_out)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int          CLK_PERIOD = 10;
  localparam int unsigned N          = 8;
  localparam logic [31:0] KIND       = 32'h0000_00F0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_ren;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.N_INPUTS(N), .KIND_MASK(KIND)) i_irqc_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    step();
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_ren = 1'b1;
    #1;
    d = bus_rdata;
    bus_ren = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] p);
    for (int k = 0; k < 32; k++) if (p[k]) return k;
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    bus_ren = 1'b0; irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd_check("R1 status", 3'd0, 32'h0);
    rd_check("R1 enable", 3'd2, 32'h0);
    rd_check("R1 master", 3'd7, 32'h0);
    rd_check("R1 vector", 3'd6, 32'hFFFF_FFFF);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R8 master readback
    wr(3'd7, 32'h3);          rd_check("R8 master 3", 3'd7, 32'h3);
    wr(3'd7, 32'hFFFF_FFFE);  rd_check("R8 master upper", 3'd7, 32'h2);
    wr(3'd7, 32'h1);          rd_check("R8 master 1", 3'd7, 32'h1);
    wr(3'd7, 32'h0);          rd_check("R8 master 0", 3'd7, 32'h0);

    // R5 / R10 enable access
    wr(3'd2, 32'hFFFF_FFFF);  rd_check("R10 enable upper", 3'd2, 32'hFF);
    wr(3'd2, 32'h0);          rd_check("R5 enable zero", 3'd2, 32'h0);
    wr(3'd4, 32'h0F);         rd_check("R5 set", 3'd2, 32'h0F);
    wr(3'd4, 32'h30);         rd_check("R5 set keeps", 3'd2, 32'h3F);
    wr(3'd5, 32'h05);         rd_check("R5 clear", 3'd2, 32'h3A);
    rd_check("R10 ack reads 0", 3'd3, 32'h0);
    rd_check("R10 set reads 0", 3'd4, 32'h0);
    rd_check("R10 clr reads 0", 3'd5, 32'h0);
    wr(3'd2, 32'hFF);

    // R3 level lines
    for (int i = 0; i < 4; i++) begin
      irq_in[i] = 1'b1; step();
      rd_check("R3 level capture", 3'd0, 32'(1) << i);
      wr(3'd3, 32'(1) << i);
      rd_check("R3 ack while high", 3'd0, 32'(1) << i);
      irq_in[i] = 1'b0; step();
      rd_check("R3 latched after low", 3'd0, 32'(1) << i);
      wr(3'd3, 32'(1) << i);
      rd_check("R3 ack after low", 3'd0, 32'h0);
    end

    // R2 edge lines
    for (int i = 4; i < 8; i++) begin
      irq_in[i] = 1'b1; step();
      rd_check("R2 edge capture", 3'd0, 32'(1) << i);
      wr(3'd3, 32'(1) << i);
      rd_check("R2 no recapture while high", 3'd0, 32'h0);
      step();
      rd_check("R2 still clear", 3'd0, 32'h0);
      irq_in[i] = 1'b0; step();
      irq_in[i] = 1'b1; step();
      irq_in[i] = 1'b0; step();
      rd_check("R2 held after fall", 3'd0, 32'(1) << i);
      wr(3'd3, 32'(1) << i);
      rd_check("R2 ack clears", 3'd0, 32'h0);
    end

    // R4 acknowledge masks
    irq_in = 8'hFF; step();
    irq_in = 8'h00; step();
    rd_check("R4 all captured", 3'd0, 32'hFF);
    wr(3'd3, 32'h81);          rd_check("R4 partial ack", 3'd0, 32'h7E);
    wr(3'd3, 32'hFFFF_FFFF);   rd_check("R4 ack all", 3'd0, 32'h0);

    // R6 / R7 / R9 sweep of every enable pattern over a full status
    irq_in = 8'h0F; step();
    irq_in[7:4] = 4'hF; step();
    irq_in[7:4] = 4'h0;
    wr(3'd7, 32'h3);
    for (int e = 0; e < 256; e++) begin
      wr(3'd2, 32'(e));
      rd_check("R6 status", 3'd0, 32'hFF);
      rd_check("R6 pending", 3'd1, 32'(e));
      rd_check("R7 vector", 3'd6, lowest(32'(e)));
      step();
      check("R9 irq_out", {31'b0, irq_out}, {31'b0, (e != 0)});
    end

    // R9 master gating
    wr(3'd2, 32'hFF);
    wr(3'd7, 32'h1); step(); check("R9 master 1 only", {31'b0, irq_out}, 32'h0);
    wr(3'd7, 32'h2); step(); check("R9 master 2 only", {31'b0, irq_out}, 32'h0);
    wr(3'd7, 32'h3); step(); check("R9 both on", {31'b0, irq_out}, 32'h1);
    irq_in = '0;
    wr(3'd3, 32'hFF); step();
    check("R9 low when none pending", {31'b0, irq_out}, 32'h0);
    rd_check("R7 vector none", 3'd6, 32'hFFFF_FFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule